// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Unit

This block produces the interrupt handshake between two processors that share a dual-port memory. The two highest locations of the shared address space are reserved as mailboxes, one per direction. Each mailbox belongs to one port and drives that port's active-low interrupt. A processor sends a message in three steps. It writes the payload into ordinary shared locations. It then writes the other side's mailbox, which raises the other side's interrupt. The receiving processor's service routine reads or writes its own mailbox, and that access clears the interrupt.

The general storage array and the collision arbitration sit outside this block. Each port is seen only as a plain bus: enable, write strobe, address and write data. The unit keeps the two mailbox words itself and returns them on a registered read path. No port carries a valid/ready handshake. An access is taken in the cycle its enable is high and is never stalled, so there is no back-pressure.

Port 0 is the left side and port 1 the right side. The left mailbox sits at the all-ones address minus one (0xFFFE for 16-bit addresses). The right mailbox sits at the all-ones address (0xFFFF).

Top module: `dp_mailbox_irq`

## Requirements
- R1: After reset both interrupt outputs are high (inactive), both mailbox words are zero, and both read data outputs are zero.
- R2: A left write (`l_en`=1, `l_we`=1) to address 0xFFFF drives `r_irq_n` low from the clock edge that takes the write.
- R3: A right write to address 0xFFFE drives `l_irq_n` low from the clock edge that takes the write.
- R4: A right access to 0xFFFF clears `r_irq_n` to high on that edge, whether the access is a read or a write. A left access to 0xFFFE clears `l_irq_n` in the same way.
- R5: An asserted interrupt stays low until it is cleared. None of the following changes either interrupt:
  - accesses to any other address;
  - a port reading the other port's mailbox;
  - a port writing its own mailbox, for the other port's interrupt;
  - any cycle with the enable low.
- R6: When one interrupt is both set and cleared in the same cycle, the set wins and the output is low after that edge.
- R7: Mailbox words are stored like ordinary words. A read (`en`=1, `we`=0) of either mailbox address returns the stored word on that port's `rdata` one cycle later. Any other cycle returns zero on `rdata`.
- R8: If both ports write the same mailbox in one cycle, the word written by the non-owning (sending) port is stored.
- R9: A read of a mailbox in the same cycle as a write to it returns the value the word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write strobe (1 = write) |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port mailbox read data, one cycle after the read |
| l_irq_n | output | 1 | Interrupt to the left processor, active low |
| r_en | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write strobe (1 = write) |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port mailbox read data, one cycle after the read |
| r_irq_n | output | 1 | Interrupt to the right processor, active low |

## Verification
The hardest case to reach is a set and a clear of the same interrupt landing on one edge. It only occurs when both processors touch the same mailbox in the same cycle, which ordinary message traffic never lines up. The stimulus drives both ports from one task call. That lets it place the sender's mailbox write and the receiver's service access on the same edge. It does this both while the interrupt is already pending and while it is idle. The same cycle-aligned stimulus also produces two other cases: two writes to one mailbox at once, and a read racing a write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L = 0;
  localparam int unsigned PORT_R = 1;

  // Address of the mailbox owned by port idx: all-ones minus one for the
  // left port, all-ones for the right port.
  function automatic logic [63:0] box_addr(input int unsigned aw, input int unsigned idx);
    logic [63:0] ones;
    ones = (64'd1 << aw) - 64'd1;
    return ones - 64'd1 + 64'(idx);
  endfunction
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OWN_IDX = 0
) (
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc_own,
  output logic              wr_own,
  output logic              rd_own,
  output logic              wr_peer,
  output logic              rd_peer
);
  import mbx_pkg::*;
  localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(box_addr(ADDR_W, OWN_IDX));
  localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(box_addr(ADDR_W, NUM_PORTS - 1 - OWN_IDX));

  logic hit_own, hit_peer;
  assign hit_own  = en && (addr == OWN_A);
  assign hit_peer = en && (addr == PEER_A);
  assign acc_own  = hit_own;
  assign wr_own   = hit_own && we;
  assign rd_own   = hit_own && !we;
  assign wr_peer  = hit_peer && we;
  assign rd_peer  = hit_peer && !we;
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign irq_n = !pend_q;

  // R2/R3: a set asserts the interrupt after the edge; R6: even with a clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> !irq_n);
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> irq_n);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(irq_n));
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              peer_wr,
  input  logic [DATA_W-1:0] peer_wdata,
  input  logic              own_wr,
  input  logic [DATA_W-1:0] own_wdata,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word <= '0;
    else if (peer_wr) word <= peer_wdata;
    else if (own_wr)  word <= own_wdata;
  end

  a_r8_sender_wins: assert property (@(posedge clk) disable iff (!rst_n)
    peer_wr |=> (word == $past(peer_wdata)));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!peer_wr && !own_wr) |=> $stable(word));
endmodule

// File: rtl/dp_mailbox_irq.sv
module dp_mailbox_irq #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);
  import mbx_pkg::*;
  localparam int unsigned NP = NUM_PORTS;
  localparam logic [ADDR_W-1:0] R_BOX = ADDR_W'(box_addr(ADDR_W, PORT_R));
  localparam logic [ADDR_W-1:0] L_BOX = ADDR_W'(box_addr(ADDR_W, PORT_L));

  logic              en    [NP];
  logic              we    [NP];
  logic [ADDR_W-1:0] addr  [NP];
  logic [DATA_W-1:0] wdata [NP];
  logic [DATA_W-1:0] rdq   [NP];
  logic              irqn  [NP];
  logic [DATA_W-1:0] box   [NP];
  logic acc_own [NP], wr_own [NP], rd_own [NP], wr_peer [NP], rd_peer [NP];

  assign en[PORT_L]    = l_en;
  assign we[PORT_L]    = l_we;
  assign addr[PORT_L]  = l_addr;
  assign wdata[PORT_L] = l_wdata;
  assign en[PORT_R]    = r_en;
  assign we[PORT_R]    = r_we;
  assign addr[PORT_R]  = r_addr;
  assign wdata[PORT_R] = r_wdata;

  for (genvar g = 0; g < NP; g++) begin : g_port
    localparam int unsigned PEER = NP - 1 - g;

    mbx_port_dec #(.ADDR_W(ADDR_W), .OWN_IDX(g)) u_dec (
      .en(en[g]), .we(we[g]), .addr(addr[g]),
      .acc_own(acc_own[g]), .wr_own(wr_own[g]), .rd_own(rd_own[g]),
      .wr_peer(wr_peer[g]), .rd_peer(rd_peer[g])
    );

    mbx_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set_i(wr_peer[PEER]), .clr_i(acc_own[g]),
      .irq_n(irqn[g])
    );

    mbx_store #(.DATA_W(DATA_W)) u_box (
      .clk(clk), .rst_n(rst_n),
      .peer_wr(wr_peer[PEER]), .peer_wdata(wdata[PEER]),
      .own_wr(wr_own[g]), .own_wdata(wdata[g]),
      .word(box[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rdq[g] <= '0;
      else if (rd_own[g])  rdq[g] <= box[g];
      else if (rd_peer[g]) rdq[g] <= box[PEER];
      else                 rdq[g] <= '0;
    end
  end

  assign l_rdata = rdq[PORT_L];
  assign r_rdata = rdq[PORT_R];
  assign l_irq_n = irqn[PORT_L];
  assign r_irq_n = irqn[PORT_R];

  // Port-level checks
  a_r2_left_raises_right: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && l_we && l_addr == R_BOX) |=> !r_irq_n);
  a_r3_right_raises_left: assert property (@(posedge clk) disable iff (!rst_n)
    (r_en && r_we && r_addr == L_BOX) |=> !l_irq_n);
  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_en && !r_en) |=> ($stable(l_irq_n) && $stable(r_irq_n)));
  a_r7_quiet_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_en && !r_en) |=> (l_rdata == '0 && r_rdata == '0));
  a_r9_read_old: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && !l_we && l_addr == R_BOX) |=> (l_rdata == $past(box[PORT_R])));
  always_comb begin
    if (!rst_n) a_r1_reset_idle: assert (l_irq_n && r_irq_n);
  end
endmodule

// File: tb/tb_dp_mailbox_irq.sv
module tb_dp_mailbox_irq;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [AW-1:0] LBOX = 16'hFFFE;
  localparam logic [AW-1:0] RBOX = 16'hFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_en = 0, l_we = 0, r_en = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  always #5 clk = ~clk;

  dp_mailbox_irq #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  typedef struct packed {
    logic lirq_n;
    logic rirq_n;
    logic [DW-1:0] lrd;
    logic [DW-1:0] rrd;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state built from the requirements
  logic m_lp = 0, m_rp = 0;
  logic [DW-1:0] m_lbox = '0, m_rbox = '0;

  task automatic cyc(input string tag,
                     input logic le, input logic lw, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                     input logic re, input logic rw, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
    exp_t e;
    logic lset, lclr, rset, rclr;
    l_en = le; l_we = lw; l_addr = la; l_wdata = ld;
    r_en = re; r_we = rw; r_addr = ra; r_wdata = rd;
    // read data from the values held before this edge
    e.lrd = (le && !lw && la == LBOX) ? m_lbox : (le && !lw && la == RBOX) ? m_rbox : '0;
    e.rrd = (re && !rw && ra == RBOX) ? m_rbox : (re && !rw && ra == LBOX) ? m_lbox : '0;
    lset = re && rw && ra == LBOX;
    lclr = le && la == LBOX;
    rset = le && lw && la == RBOX;
    rclr = re && ra == RBOX;
    m_lp = lset ? 1'b1 : lclr ? 1'b0 : m_lp;
    m_rp = rset ? 1'b1 : rclr ? 1'b0 : m_rp;
    if (lset) m_lbox = rd; else if (le && lw && la == LBOX) m_lbox = ld;
    if (rset) m_rbox = ld; else if (re && rw && ra == RBOX) m_rbox = rd;
    e.lirq_n = !m_lp;
    e.rirq_n = !m_rp;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  task automatic cmp(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // monitor: pop one expected item per edge and compare
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp(t, "l_irq_n", {{(DW-1){1'b0}}, l_irq_n}, {{(DW-1){1'b0}}, e.lirq_n});
      cmp(t, "r_irq_n", {{(DW-1){1'b0}}, r_irq_n}, {{(DW-1){1'b0}}, e.rirq_n});
      cmp(t, "l_rdata", l_rdata, e.lrd);
      cmp(t, "r_rdata", r_rdata, e.rrd);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (l_irq_n !== 1'b1 || r_irq_n !== 1'b1) begin
      failures++;
      $display("FAIL R1 irq in reset actual=%b%b expected=11", l_irq_n, r_irq_n);
    end
    rst_n = 1'b1;
    @(negedge clk);
    idle("R1");
    cyc("R1", 1, 0, LBOX, '0, 1, 0, RBOX, '0);             // both boxes read zero
    cyc("R5", 1, 1, 16'h0010, 16'h00AA, 0, 0, '0, '0);     // payload word
    cyc("R2", 1, 1, RBOX, 16'hA5A5, 0, 0, '0, '0);
    idle("R5");
    cyc("R5", 0, 0, '0, '0, 1, 0, LBOX, '0);               // peer box read, no clear
    cyc("R5", 0, 0, '0, '0, 0, 0, RBOX, '0);               // enable low
    cyc("R5", 1, 1, 16'h1234, 16'h0, 1, 1, 16'h0000, 16'h1);
    cyc("R5", 1, 0, RBOX, '0, 0, 0, '0, '0);               // left reads right box
    cyc("R4", 0, 0, '0, '0, 1, 0, RBOX, '0);               // read clears right
    cyc("R3", 0, 0, '0, '0, 1, 1, LBOX, 16'h1234);
    cyc("R5", 1, 1, RBOX, 16'h0BEE, 0, 0, '0, '0);         // also raises right
    cyc("R4", 1, 1, LBOX, 16'h7777, 1, 1, RBOX, 16'h5555); // writes clear both
    cyc("R7", 1, 0, LBOX, '0, 1, 0, LBOX, '0);
    cyc("R6", 1, 0, LBOX, '0, 1, 1, LBOX, 16'hC0DE);       // set+clear, read old (R9)
    cyc("R9", 1, 0, LBOX, '0, 0, 0, '0, '0);
    cyc("R6", 1, 1, RBOX, 16'h4242, 1, 0, RBOX, '0);       // set+clear on right
    cyc("R8", 1, 1, RBOX, 16'h1111, 1, 1, RBOX, 16'h2222); // sender wins
    cyc("R8", 1, 0, RBOX, '0, 1, 0, RBOX, '0);
    cyc("R8", 1, 1, LBOX, 16'h3333, 1, 1, LBOX, 16'h4444);
    cyc("R7", 1, 0, LBOX, '0, 1, 0, 16'h0010, '0);
    cyc("R4", 1, 0, LBOX, '0, 0, 0, '0, '0);
    idle("R5");
    idle("R1");
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
    end
    @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule